// File: doc/BRIEF.md
# Pixel Time-over-Threshold Counter

This block is the digital tail of one pixel. It takes the raw output of the pixel's discriminator, which may change at any moment, and brings it into the system clock domain. It then counts how many clock periods that output stays high, which gives an estimate of the deposited charge. With a 5-bit counter and an 80 MHz counting clock, the usable range is 31 periods (about 400 ns). A pulse that outlasts the range is reported at once as a saturated value with a timeout flag. The rest of that pulse is ignored.

The same block also holds the pixel's small configuration word. This word carries a 4-bit threshold-trim code, which drives the pixel's local correction DAC, and a mask bit. The mask silences hit reporting, but it does not block later configuration writes. Each finished measurement appears as a one-cycle strobe together with the count and the timeout flag.

Top module: `pix_tot_core`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `hit_valid`, `hit_tot`, `hit_timeout` and `trim_o` are all zero, and the mask is clear.
- R2: An unmasked discriminator pulse that the synchroniser sees high for N consecutive clock cycles, with 1 <= N <= 31, is reported once with `hit_tot` = N and `hit_timeout` = 0. A reported count is never zero.
- R3: `hit_valid` is high for exactly one cycle per report and is never high on two consecutive cycles. `hit_tot` and `hit_timeout` keep the last reported values between reports.
- R4: A pulse seen high for 32 or more cycles is reported while it is still high, with `hit_tot` = 31 and `hit_timeout` = 1. `hit_timeout` is 1 only when `hit_tot` is 31.
- R5: When a pulse has timed out, its later falling edge produces no second report.
- R6: A new pulse is accepted only after the previous one has been reported and the synchronised discriminator has been seen low for at least one cycle. A single low cycle between a timed-out pulse and the next pulse is enough to re-arm.
- R7: A write with `cfg_we` = 1 loads `cfg_wdata[3:0]` as the trim code and `cfg_wdata[4]` as the mask. The new trim appears on `trim_o` on the cycle after the write edge.
- R8: While the mask bit is set, no `hit_valid` is produced. Configuration writes still take effect while the mask is set.
- R9: Whether a report is shown or suppressed depends on the mask value held before the clock edge at which the report is decided. A mask write on that same edge affects only later reports.
- R10: If `disc_in` is first sampled low at clock edge k, the `hit_valid` for that pulse is high after edge k+2. Counting starts on the edge after the synchronised rising edge is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_in | input | 1 | Discriminator output, asynchronous to clk |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 5 | Bit 4 is the mask; bits 3:0 are the trim code |
| trim_o | output | 4 | Stored threshold-trim code for the local DAC |
| hit_valid | output | 1 | One-cycle strobe marking a reported hit |
| hit_tot | output | 5 | Time-over-threshold count of the reported hit |
| hit_timeout | output | 1 | Set when the reported hit saturated the counter |

## Verification
Two functions can fall on the same clock edge. One is a configuration write that flips the mask. The other is the decision to report a pulse, whether on its falling edge or on its timeout. The bench provokes this coincidence by placing the write exactly on the decision edge in both directions: unmasking into a masked pulse, and masking into an unmasked one. Under R9, the first case must stay silent and the second must still report. A behavioural model compared on every clock judges the outcome. Directed checks around widths 31, 32 and beyond, and a one-cycle re-arm gap, cover the case where a timeout and a falling edge fall close together.

// File: rtl/pix_tot_pkg.sv
package pix_tot_pkg;

    // Default geometry of one pixel's digital tail
    localparam int TOT_W_DEF   = 5;  // counter width: 31 usable periods
    localparam int TRIM_W_DEF  = 4;  // local threshold-correction code width
    localparam int SYNC_N_DEF  = 2;  // synchroniser depth

    // Measurement states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // armed, waiting for a synchronised rising edge
        ST_COUNT = 2'd1,   // discriminator high, counter running
        ST_HOLD  = 2'd2    // saturated and reported, waiting for the line to drop
    } meas_state_e;

endpackage

// File: rtl/pix_tot_sync.sv
module pix_tot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        if (STAGES == 1) begin
            sync_d[0] = d;
        end else begin
            sync_d = {sync_q[STAGES-2:0], d};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign q = sync_q[STAGES-1];

endmodule

// File: rtl/pix_tot_cfg.sv
module pix_tot_cfg #(
    parameter int TRIM_W = 4,
    localparam int CFG_W = TRIM_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_W-1:0]  wdata,
    output logic [TRIM_W-1:0] trim,
    output logic              mask
);

    typedef struct packed {
        logic              mask;
        logic [TRIM_W-1:0] trim;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.trim = wdata[TRIM_W-1:0];
            cfg_d.mask = wdata[CFG_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign trim = cfg_q.trim;
    assign mask = cfg_q.mask;

endmodule

// File: rtl/pix_tot_meas.sv
module pix_tot_meas
    import pix_tot_pkg::*;
#(
    parameter int TOT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disc_s,
    input  logic             mask,
    output logic             valid,
    output logic [TOT_W-1:0] tot,
    output logic             timeout
);

    localparam logic [TOT_W-1:0] CNT_MAX = '1;
    localparam logic [TOT_W-1:0] CNT_ONE = TOT_W'(1);

    typedef struct packed {
        meas_state_e      state;
        logic             prev;
        logic [TOT_W-1:0] cnt;
        logic             valid;
        logic [TOT_W-1:0] tot;
        logic             tmo;
    } meas_t;

    meas_t m_d, m_q;
    logic  report;
    logic  rep_tmo;

    always_comb begin
        m_d       = m_q;
        m_d.valid = 1'b0;
        m_d.prev  = disc_s;
        report    = 1'b0;
        rep_tmo   = 1'b0;

        unique case (m_q.state)
            ST_IDLE: begin
                if (disc_s && !m_q.prev) begin
                    m_d.state = ST_COUNT;
                    m_d.cnt   = CNT_ONE;
                end
            end
            ST_COUNT: begin
                if (!disc_s) begin
                    report    = 1'b1;
                    m_d.state = ST_IDLE;
                end else if (m_q.cnt == CNT_MAX) begin
                    report    = 1'b1;
                    rep_tmo   = 1'b1;
                    m_d.state = ST_HOLD;
                end else begin
                    m_d.cnt = m_q.cnt + CNT_ONE;
                end
            end
            ST_HOLD: begin
                if (!disc_s) begin
                    m_d.state = ST_IDLE;
                end
            end
            default: m_d.state = ST_IDLE;
        endcase

        if (report && !mask) begin
            m_d.valid = 1'b1;
            m_d.tot   = m_q.cnt;
            m_d.tmo   = rep_tmo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{state: ST_IDLE, prev: 1'b0, cnt: '0,
                     valid: 1'b0, tot: '0, tmo: 1'b0};
        end else begin
            m_q <= m_d;
        end
    end

    assign valid   = m_q.valid;
    assign tot     = m_q.tot;
    assign timeout = m_q.tmo;

endmodule

// File: rtl/pix_tot_core.sv
module pix_tot_core
    import pix_tot_pkg::*;
#(
    parameter int TOT_W  = TOT_W_DEF,
    parameter int TRIM_W = TRIM_W_DEF,
    parameter int SYNC_N = SYNC_N_DEF,
    localparam int CFG_W = TRIM_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disc_in,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [TRIM_W-1:0] trim_o,
    output logic              hit_valid,
    output logic [TOT_W-1:0]  hit_tot,
    output logic              hit_timeout
);

    logic disc_s;
    logic cfg_mask;

    pix_tot_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (disc_in),
        .q     (disc_s)
    );

    pix_tot_cfg #(.TRIM_W(TRIM_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .trim  (trim_o),
        .mask  (cfg_mask)
    );

    pix_tot_meas #(.TOT_W(TOT_W)) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .disc_s  (disc_s),
        .mask    (cfg_mask),
        .valid   (hit_valid),
        .tot     (hit_tot),
        .timeout (hit_timeout)
    );

endmodule

// File: rtl/pix_tot_chk.sv
module pix_tot_chk #(
    parameter int TOT_W  = 5,
    parameter int TRIM_W = 4,
    localparam int CFG_W = TRIM_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic [TRIM_W-1:0] trim_o,
    input logic              cfg_mask,
    input logic              hit_valid,
    input logic [TOT_W-1:0]  hit_tot,
    input logic              hit_timeout
);

    localparam logic [TOT_W-1:0] SAT = '1;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> !hit_valid); // R3

    AST_TOT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> hit_tot != '0); // R2

    AST_TIMEOUT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_timeout) |-> hit_tot == SAT); // R4

    AST_FLAG_ONLY_AT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_tot != SAT) |-> !hit_timeout); // R4

    AST_TRIM_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we) |-> trim_o == $past(cfg_wdata[TRIM_W-1:0])); // R7

    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_mask) |-> !hit_valid); // R8

endmodule

bind pix_tot_core pix_tot_chk #(.TOT_W(TOT_W), .TRIM_W(TRIM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .trim_o      (trim_o),
    .cfg_mask    (cfg_mask),
    .hit_valid   (hit_valid),
    .hit_tot     (hit_tot),
    .hit_timeout (hit_timeout)
);

// File: tb/sim_pix_tot_core.sv
`timescale 1ns/1ps
module sim_pix_tot_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disc_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic [3:0] trim_o;
    logic       hit_valid;
    logic [4:0] hit_tot;
    logic       hit_timeout;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pix_tot_core u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .disc_in     (disc_in),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .trim_o      (trim_o),
        .hit_valid   (hit_valid),
        .hit_tot     (hit_tot),
        .hit_timeout (hit_timeout)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_s1, m_s2, m_prev, m_mode, m_cnt, m_mask, m_trim;
    int e_valid, e_tot, e_to;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_mode = 0; m_cnt = 0;
            m_mask = 0; m_trim = 0; e_valid = 0; e_tot = 0; e_to = 0;
        end else begin
            int fire, fire_to;
            fire = 0; fire_to = 0;
            e_valid = 0;
            if (m_mode == 0) begin
                if (m_s2 == 1 && m_prev == 0) begin m_mode = 1; m_cnt = 1; end
            end else if (m_mode == 1) begin
                if (m_s2 == 0) begin fire = 1; m_mode = 0; end
                else if (m_cnt >= 31) begin fire = 1; fire_to = 1; m_mode = 2; end
                else m_cnt = m_cnt + 1;
            end else begin
                if (m_s2 == 0) m_mode = 0;
            end
            if (fire == 1 && m_mask == 0) begin
                e_valid = 1; e_tot = m_cnt; e_to = fire_to;
            end
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = int'(disc_in);
            if (cfg_we) begin
                m_mask = int'(cfg_wdata[4]);
                m_trim = int'(cfg_wdata[3:0]);
            end
        end
    end

    // compare every cycle, away from the active edge (R10 timing, R3 hold)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(int'(hit_valid) == e_valid, "R10", "model hit_valid", int'(hit_valid), e_valid);
            check(int'(hit_tot) == e_tot, "R3", "model hit_tot", int'(hit_tot), e_tot);
            check(int'(hit_timeout) == e_to, "R4", "model hit_timeout", int'(hit_timeout), e_to);
            check(int'(trim_o) == m_trim, "R7", "model trim_o", int'(trim_o), m_trim);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic cfg_write(input logic [4:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive a pulse of w clock periods; optional config write at slot cfg_at.
    task automatic pulse(input int w, input bit masked, input int cfg_at,
                         input logic [4:0] cfg_val, input string req);
        int nval, got_tot, got_to, exp_tot, exp_to;
        nval = 0; got_tot = -1; got_to = -1;
        exp_tot = (w > 31) ? 31 : w;
        exp_to  = (w > 31) ? 1 : 0;
        disc_in = 1'b1;
        for (int i = 0; i < w + 12; i++) begin
            @(negedge clk);
            if (hit_valid) begin
                nval++;
                got_tot = int'(hit_tot);
                got_to = int'(hit_timeout);
            end
            if (i == w - 1) disc_in = 1'b0;
            cfg_we = (i == cfg_at);
            if (i == cfg_at) cfg_wdata = cfg_val;
        end
        cfg_we = 1'b0;
        check(nval == (masked ? 0 : 1), req, $sformatf("report count w=%0d", w),
              nval, masked ? 0 : 1);
        if (!masked) begin
            check(got_tot == exp_tot, req, $sformatf("tot w=%0d", w), got_tot, exp_tot);
            check(got_to == exp_to, req, $sformatf("timeout w=%0d", w), got_to, exp_to);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(hit_valid == 1'b0, "R1", "hit_valid in reset", int'(hit_valid), 0);
        check(trim_o == 4'd0, "R1", "trim_o in reset", int'(trim_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(hit_tot == 5'd0 && hit_timeout == 1'b0, "R1", "hit fields after reset",
              int'({hit_timeout, hit_tot}), 0);

        // R7: trim load
        cfg_write(5'h0A);
        check(trim_o == 4'hA, "R7", "trim after write", int'(trim_o), 10);
        repeat (2) @(negedge clk);

        // R2: several widths
        pulse(1, 0, -1, '0, "R2");
        pulse(5, 0, -1, '0, "R2");
        pulse(17, 0, -1, '0, "R2");
        pulse(31, 0, -1, '0, "R4");   // boundary: full count, no flag
        // R4/R5: timeout and ignored tail
        pulse(32, 0, -1, '0, "R4");
        pulse(45, 0, -1, '0, "R5");
        for (int w = 2; w <= 35; w += 3) pulse(w, 0, -1, '0, "R2");

        // R6: one low cycle after a timed-out pulse re-arms
        begin
            int hits, t0, f0, t1, f1;
            hits = 0; t0 = -1; f0 = -1; t1 = -1; f1 = -1;
            disc_in = 1'b1;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (hit_valid) begin
                    if (hits == 0) begin t0 = int'(hit_tot); f0 = int'(hit_timeout); end
                    else begin t1 = int'(hit_tot); f1 = int'(hit_timeout); end
                    hits++;
                end
                if (i == 39) disc_in = 1'b0;
                if (i == 40) disc_in = 1'b1;
                if (i == 43) disc_in = 1'b0;
            end
            check(hits == 2, "R6", "reports across re-arm", hits, 2);
            check(t0 == 31 && f0 == 1, "R6", "first report tot", t0, 31);
            check(t1 == 3 && f1 == 0, "R6", "second report tot", t1, 3);
        end

        // R8: mask silences reports, writes still work
        cfg_write(5'h15);
        check(trim_o == 4'h5, "R8", "trim written with mask", int'(trim_o), 5);
        pulse(6, 1, -1, '0, "R8");
        pulse(40, 1, -1, '0, "R8");
        cfg_write(5'h13);
        check(trim_o == 4'h3, "R8", "trim rewritten while masked", int'(trim_o), 3);

        // R9: unmask on the decision edge of a masked pulse -> still silent
        pulse(4, 1, 5, 5'h03, "R9");
        check(trim_o == 4'h3, "R9", "trim after unmask", int'(trim_o), 3);
        // R9: mask on the decision edge of an unmasked pulse -> still reported
        pulse(7, 0, 8, 5'h17, "R9");
        pulse(3, 1, -1, '0, "R9");
        cfg_write(5'h07);
        pulse(9, 0, -1, '0, "R9");

        repeat (4) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule